// File: doc/BRIEF.md
# Odd-Even Non-Minimal Direction Filter

This block does the route computation for one router in a two-dimensional mesh. For each packet at the router it returns three 4-bit direction masks. The first holds directions that shorten the path. The second holds directions at right angles to the shortening ones. The third holds directions that lengthen the path along an axis the packet still has to cover. A selection stage further down can prefer the first mask and use the others as detours when links are congested or broken.

Every direction in the masks obeys the odd-even turn model, so the detours cannot form a deadlock cycle. A set of destination-dependent restrictions is applied on top of the turn model. These restrictions stop a packet from being sent somewhere it can no longer get out of. When the packet is at its destination, a local-eject flag is raised in place of any direction.

The inputs are:
- the router's own column and row;
- the destination column and row;
- the column where the packet was injected;
- the heading of its last hop.

The computation is combinational. A parameter selects whether the outputs are registered.

Top module: `noe_dir_filter`

## Requirements
- R1: When the current coordinates equal the destination, eject_o is 1 and all three masks are 0000. Otherwise eject_o is 0.
- R2: Mask bits are N=bit0, E=bit1, S=bit2, W=bit3. North means increasing row and east means increasing column. A legal direction goes in min_mask_o if it reduces the distance to the destination. It goes in side_mask_o if it moves along an axis on which the destination offset is zero. It goes in back_mask_o if it increases the offset on an axis where the offset is nonzero. The three masks never share a bit.
- R3: in_dir_i gives the heading of the last hop: 0 local injection, 1 north, 2 east, 3 south, 4 west. The direction opposite to that heading is never offered.
- R4: In an even column, a packet heading east is offered neither North nor South.
- R5: In an odd column, a packet heading north or south is not offered West.
- R6: No direction that would leave the mesh is offered.
- R7: When the destination column is west of the current column, East is never offered. In that case, North and South are also withheld in an odd column, unless that column is the source column.
- R8: When the destination is in the current column and north of it, East is withheld, and South is withheld in odd columns and in column 0. When the destination is south of it, East is withheld, and North is withheld in odd columns and in column 0.
- R9: This rule covers a router in an odd column whose destination is in the even column directly east. With the same row, North and South are withheld. With the destination to the north, East and South are withheld. With the destination to the south, East and North are withheld.
- R10: With REG_OUT=1 the outputs show the result for the inputs of the previous clock edge. During reset they are all zero.
- R11: For a locally injected packet (in_dir_i=0), the turn restrictions R3 to R5 do not apply. Only R6 to R9 constrain it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_x_i | input | 3 | Column of this router |
| cur_y_i | input | 3 | Row of this router |
| dst_x_i | input | 3 | Destination column |
| dst_y_i | input | 3 | Destination row |
| src_x_i | input | 3 | Column where the packet was injected |
| in_dir_i | input | 3 | Heading of the last hop (0 local, 1 N, 2 E, 3 S, 4 W) |
| eject_o | output | 1 | Packet has reached its destination |
| min_mask_o | output | 4 | Legal directions that shorten the path |
| side_mask_o | output | 4 | Legal directions at right angles to the minimal ones |
| back_mask_o | output | 4 | Legal directions opposite to the minimal ones |

## Verification
The assertions assume that the coordinates stay inside the mesh. They also assume that in_dir_i holds one of its five defined codes, and that a heading is consistent with the router position; for example, no packet heading east arrives in column 0. The properties compare the outputs against copies of the inputs delayed by one edge. They only begin after the first capture following reset. The directed vectors and the pseudo-random sweep draw every field inside its legal range, and the headings are chosen only from the five codes. Corner routers, column 0 and odd/even column pairs are deliberately hit.

// File: rtl/noe_pkg.sv
package noe_pkg;
  typedef enum logic [2:0] {
    HEAD_LOCAL = 3'd0,
    HEAD_N     = 3'd1,
    HEAD_E     = 3'd2,
    HEAD_S     = 3'd3,
    HEAD_W     = 3'd4
  } head_e;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;
  localparam int NDIR  = 4;
endpackage

// File: rtl/noe_turn_filter.sv
module noe_turn_filter
  import noe_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  localparam int XW = $clog2(MESH_X),
  localparam int YW = $clog2(MESH_Y)
) (
  input  logic [XW-1:0]   cur_x_i,
  input  logic [YW-1:0]   cur_y_i,
  input  logic [2:0]      in_dir_i,
  output logic [NDIR-1:0] turn_ok_o
);
  logic odd_col;
  assign odd_col = cur_x_i[0];

  always_comb begin
    turn_ok_o = '1;
    // mesh boundary
    if (cur_y_i == YW'(MESH_Y-1)) turn_ok_o[DIR_N] = 1'b0;
    if (cur_y_i == '0)            turn_ok_o[DIR_S] = 1'b0;
    if (cur_x_i == XW'(MESH_X-1)) turn_ok_o[DIR_E] = 1'b0;
    if (cur_x_i == '0)            turn_ok_o[DIR_W] = 1'b0;
    case (head_e'(in_dir_i))
      HEAD_N: begin
        turn_ok_o[DIR_S] = 1'b0;
        if (odd_col) turn_ok_o[DIR_W] = 1'b0;
      end
      HEAD_S: begin
        turn_ok_o[DIR_N] = 1'b0;
        if (odd_col) turn_ok_o[DIR_W] = 1'b0;
      end
      HEAD_E: begin
        turn_ok_o[DIR_W] = 1'b0;
        if (!odd_col) begin
          turn_ok_o[DIR_N] = 1'b0;
          turn_ok_o[DIR_S] = 1'b0;
        end
      end
      HEAD_W:  turn_ok_o[DIR_E] = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/noe_dest_filter.sv
module noe_dest_filter
  import noe_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  localparam int XW = $clog2(MESH_X),
  localparam int YW = $clog2(MESH_Y)
) (
  input  logic [XW-1:0]   cur_x_i,
  input  logic [YW-1:0]   cur_y_i,
  input  logic [XW-1:0]   dst_x_i,
  input  logic [YW-1:0]   dst_y_i,
  input  logic [XW-1:0]   src_x_i,
  output logic [NDIR-1:0] dest_ok_o
);
  logic go_w, go_e, go_n, go_s, odd_col, col0, next_even;

  assign go_w      = dst_x_i < cur_x_i;
  assign go_e      = dst_x_i > cur_x_i;
  assign go_n      = dst_y_i > cur_y_i;
  assign go_s      = dst_y_i < cur_y_i;
  assign odd_col   = cur_x_i[0];
  assign col0      = cur_x_i == '0;
  assign next_even = !dst_x_i[0] && ({1'b0, cur_x_i} + 1'b1 == {1'b0, dst_x_i});

  always_comb begin
    dest_ok_o = '1;
    if (go_w) begin
      dest_ok_o[DIR_E] = 1'b0;
      if (odd_col && cur_x_i != src_x_i) begin
        dest_ok_o[DIR_N] = 1'b0;
        dest_ok_o[DIR_S] = 1'b0;
      end
    end else if (!go_e) begin
      if (go_n) begin
        dest_ok_o[DIR_E] = 1'b0;
        if (odd_col || col0) dest_ok_o[DIR_S] = 1'b0;
      end
      if (go_s) begin
        dest_ok_o[DIR_E] = 1'b0;
        if (odd_col || col0) dest_ok_o[DIR_N] = 1'b0;
      end
    end else if (next_even) begin
      // vertical travel must finish before the even destination column
      if (go_n) begin
        dest_ok_o[DIR_E] = 1'b0;
        dest_ok_o[DIR_S] = 1'b0;
      end else if (go_s) begin
        dest_ok_o[DIR_E] = 1'b0;
        dest_ok_o[DIR_N] = 1'b0;
      end else begin
        dest_ok_o[DIR_N] = 1'b0;
        dest_ok_o[DIR_S] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/noe_class_split.sv
module noe_class_split
  import noe_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  localparam int XW = $clog2(MESH_X),
  localparam int YW = $clog2(MESH_Y)
) (
  input  logic [XW-1:0]   cur_x_i,
  input  logic [YW-1:0]   cur_y_i,
  input  logic [XW-1:0]   dst_x_i,
  input  logic [YW-1:0]   dst_y_i,
  input  logic [NDIR-1:0] legal_i,
  output logic            hit_o,
  output logic [NDIR-1:0] min_o,
  output logic [NDIR-1:0] side_o,
  output logic [NDIR-1:0] back_o
);
  logic [NDIR-1:0] toward, away, keep;

  assign hit_o = (cur_x_i == dst_x_i) && (cur_y_i == dst_y_i);

  always_comb begin
    toward        = '0;
    away          = '0;
    toward[DIR_N] = dst_y_i > cur_y_i;
    toward[DIR_S] = dst_y_i < cur_y_i;
    toward[DIR_E] = dst_x_i > cur_x_i;
    toward[DIR_W] = dst_x_i < cur_x_i;
    away[DIR_N]   = toward[DIR_S];
    away[DIR_S]   = toward[DIR_N];
    away[DIR_E]   = toward[DIR_W];
    away[DIR_W]   = toward[DIR_E];
  end

  assign keep   = hit_o ? '0 : legal_i;
  assign min_o  = keep & toward;
  assign back_o = keep & away;
  assign side_o = keep & ~(toward | away);
endmodule

// File: rtl/noe_dir_filter.sv
module noe_dir_filter
  import noe_pkg::*;
#(
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cur_x_i,
  input  logic [2:0] cur_y_i,
  input  logic [2:0] dst_x_i,
  input  logic [2:0] dst_y_i,
  input  logic [2:0] src_x_i,
  input  logic [2:0] in_dir_i,
  output logic       eject_o,
  output logic [3:0] min_mask_o,
  output logic [3:0] side_mask_o,
  output logic [3:0] back_mask_o
);
  logic [NDIR-1:0] turn_ok, dest_ok, min_c, side_c, back_c;
  logic            hit_c;

  noe_turn_filter #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_turn (
    .cur_x_i  (cur_x_i),
    .cur_y_i  (cur_y_i),
    .in_dir_i (in_dir_i),
    .turn_ok_o(turn_ok)
  );

  noe_dest_filter #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_dest (
    .cur_x_i  (cur_x_i),
    .cur_y_i  (cur_y_i),
    .dst_x_i  (dst_x_i),
    .dst_y_i  (dst_y_i),
    .src_x_i  (src_x_i),
    .dest_ok_o(dest_ok)
  );

  noe_class_split #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_split (
    .cur_x_i(cur_x_i),
    .cur_y_i(cur_y_i),
    .dst_x_i(dst_x_i),
    .dst_y_i(dst_y_i),
    .legal_i(turn_ok & dest_ok),
    .hit_o  (hit_c),
    .min_o  (min_c),
    .side_o (side_c),
    .back_o (back_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          eject_o     <= 1'b0;
          min_mask_o  <= '0;
          side_mask_o <= '0;
          back_mask_o <= '0;
        end else begin
          eject_o     <= hit_c;
          min_mask_o  <= min_c;
          side_mask_o <= side_c;
          back_mask_o <= back_c;
        end
      end
    end else begin : g_comb
      assign eject_o     = hit_c;
      assign min_mask_o  = min_c;
      assign side_mask_o = side_c;
      assign back_mask_o = back_c;
    end
  endgenerate
endmodule

// File: rtl/noe_dir_filter_chk.sv
module noe_dir_filter_chk #(
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cur_x_i,
  input logic [2:0] cur_y_i,
  input logic [2:0] dst_x_i,
  input logic [2:0] dst_y_i,
  input logic [2:0] src_x_i,
  input logic [2:0] in_dir_i,
  input logic       eject_o,
  input logic [3:0] min_mask_o,
  input logic [3:0] side_mask_o,
  input logic [3:0] back_mask_o
);
  logic [2:0] d_cx, d_cy, d_dx, d_dy, d_in;
  logic       live;
  logic [3:0] all_m;

  assign all_m = min_mask_o | side_mask_o | back_mask_o;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          live <= 1'b0;
          d_cx <= '0; d_cy <= '0; d_dx <= '0; d_dy <= '0; d_in <= '0;
        end else begin
          live <= 1'b1;
          d_cx <= cur_x_i; d_cy <= cur_y_i;
          d_dx <= dst_x_i; d_dy <= dst_y_i; d_in <= in_dir_i;
        end
      end
    end else begin : g_nodly
      assign live = 1'b1;
      assign d_cx = cur_x_i; assign d_cy = cur_y_i;
      assign d_dx = dst_x_i; assign d_dy = dst_y_i; assign d_in = in_dir_i;
    end
  endgenerate

  logic unused_src;
  assign unused_src = ^src_x_i;

  assert_eject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && d_cx == d_dx && d_cy == d_dy) |-> (eject_o && all_m == 4'b0));
  assert_no_eject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && (d_cx != d_dx || d_cy != d_dy)) |-> !eject_o);
  assert_disjoint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((min_mask_o & side_mask_o) | (min_mask_o & back_mask_o) | (side_mask_o & back_mask_o)) == 4'b0);
  assert_min_toward_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && min_mask_o[1]) |-> (d_dx > d_cx));
  assert_no_reverse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && d_in == 3'd1) |-> !all_m[2]);
  assert_even_east_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && d_in == 3'd2 && !d_cx[0]) |-> (!all_m[0] && !all_m[2]));
  assert_odd_vert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && (d_in == 3'd1 || d_in == 3'd3) && d_cx[0]) |-> !all_m[3]);
  assert_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && d_cy == 3'(MESH_Y-1)) |-> !all_m[0]);
  assert_west_dst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && d_dx < d_cx) |-> !all_m[1]);
endmodule

bind noe_dir_filter noe_dir_filter_chk #(
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
  .src_x_i(src_x_i), .in_dir_i(in_dir_i),
  .eject_o(eject_o), .min_mask_o(min_mask_o),
  .side_mask_o(side_mask_o), .back_mask_o(back_mask_o)
);

// File: tb/tb_noe_dir_filter.sv
`timescale 1ns/1ps
module tb_noe_dir_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
  logic [2:0] src_x_i = '0, in_dir_i = '0;
  logic       eject_o;
  logic [3:0] min_mask_o, side_mask_o, back_mask_o;

  int applied = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  noe_dir_filter #(.MESH_X(8), .MESH_Y(8), .REG_OUT(1'b1)) dut (
    .clk_i, .rst_ni, .cur_x_i, .cur_y_i, .dst_x_i, .dst_y_i, .src_x_i, .in_dir_i,
    .eject_o, .min_mask_o, .side_mask_o, .back_mask_o
  );

  // Reference: {eject, min[3:0], side[3:0], back[3:0]}, bits N0 E1 S2 W3
  function automatic logic [12:0] model(int cx, int cy, int dx, int dy, int sx, int h);
    logic [3:0] mn, sd, bk;
    int ox, oy;
    mn = 0; sd = 0; bk = 0;
    ox = dx - cx; oy = dy - cy;
    if (ox == 0 && oy == 0) return {1'b1, 12'b0};
    for (int d = 0; d < 4; d++) begin
      int mx, my;
      bit ok;
      mx = (d == 1) ? 1 : (d == 3) ? -1 : 0;
      my = (d == 0) ? 1 : (d == 2) ? -1 : 0;
      ok = 1;
      if (cx + mx < 0 || cx + mx > 7 || cy + my < 0 || cy + my > 7) ok = 0;        // R6
      if (h != 0) begin
        if (((h - 1) + 2) % 4 == d) ok = 0;                                          // R3
        if ((cx % 2 == 0) && h == 2 && my != 0) ok = 0;                              // R4
        if ((cx % 2 == 1) && (h == 1 || h == 3) && d == 3) ok = 0;                   // R5
      end
      if (ox < 0) begin                                                              // R7
        if (d == 1) ok = 0;
        if ((cx % 2 == 1) && cx != sx && my != 0) ok = 0;
      end else if (ox == 0) begin                                                    // R8
        if (d == 1) ok = 0;
        if (oy > 0 && d == 2 && (cx % 2 == 1 || cx == 0)) ok = 0;
        if (oy < 0 && d == 0 && (cx % 2 == 1 || cx == 0)) ok = 0;
      end else if (ox == 1 && dx % 2 == 0) begin                                     // R9
        if (oy == 0 && my != 0) ok = 0;
        if (oy > 0 && (d == 1 || d == 2)) ok = 0;
        if (oy < 0 && (d == 1 || d == 0)) ok = 0;
      end
      if (ok) begin
        int gx, gy;
        gx = (mx != 0) ? ox : oy;
        gy = (mx != 0) ? mx : my;
        if (gx == 0) sd[d] = 1'b1;
        else if (gx * gy > 0) mn[d] = 1'b1;
        else bk[d] = 1'b1;
      end
    end
    return {1'b0, mn, sd, bk};
  endfunction

  task automatic drive(int cx, int cy, int dx, int dy, int sx, int h, string tag);
    @(negedge clk_i);
    cur_x_i = 3'(cx); cur_y_i = 3'(cy); dst_x_i = 3'(dx); dst_y_i = 3'(dy);
    src_x_i = 3'(sx); in_dir_i = 3'(h);
    exp_q.push_back(model(cx, cy, dx, dy, sx, h));
    tag_q.push_back(tag);
  endtask

  // monitor: result of an edge is sampled 2 ns after it (R10 latency)
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [12:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {eject_o, min_mask_o, side_mask_o, back_mask_o};
      applied++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    applied++;
    if ({eject_o, min_mask_o, side_mask_o, back_mask_o} !== 13'b0) begin
      fails++;
      $display("FAIL R10 reset actual=%b expected=%b",
               {eject_o, min_mask_o, side_mask_o, back_mask_o}, 13'b0);
    end
    rst_ni = 1'b1;

    drive(3, 4, 3, 4, 0, 2, "R1 eject at destination");
    drive(0, 0, 0, 0, 0, 0, "R1 eject at origin");
    drive(2, 2, 5, 6, 2, 0, "R2 northeast classes");
    drive(5, 3, 5, 3, 5, 0, "R1 eject odd column");
    drive(2, 3, 2, 3, 1, 4, "R1 eject heading west");
    drive(4, 4, 7, 4, 1, 4, "R3 no reversal heading west");
    drive(4, 3, 4, 0, 4, 1, "R3 no reversal heading north");
    drive(4, 3, 6, 3, 1, 2, "R4 even column heading east");
    drive(3, 3, 3, 6, 3, 1, "R5 odd column heading north");
    drive(3, 5, 3, 1, 3, 3, "R5 odd column heading south");
    drive(7, 7, 0, 0, 7, 0, "R6 northeast corner");
    drive(0, 0, 6, 6, 0, 0, "R6 southwest corner");
    drive(5, 2, 1, 2, 7, 4, "R7 west odd non-source column");
    drive(5, 2, 1, 2, 5, 0, "R7 west odd source column");
    drive(4, 2, 1, 5, 6, 4, "R7 west even column");
    drive(0, 1, 0, 6, 0, 1, "R8 north in column 0");
    drive(3, 5, 3, 1, 3, 3, "R8 south in odd column");
    drive(2, 5, 2, 1, 2, 0, "R8 south in even column");
    drive(3, 2, 4, 2, 0, 2, "R9 next even column same row");
    drive(3, 2, 4, 6, 0, 2, "R9 next even column northeast");
    drive(3, 6, 4, 1, 0, 2, "R9 next even column southeast");
    drive(4, 3, 6, 3, 4, 0, "R11 local injection even column");
    drive(3, 3, 1, 6, 3, 0, "R11 local injection odd column");

    begin
      int unsigned s;
      s = 32'h1ace_b00c;
      for (int i = 0; i < 3000; i++) begin
        int f[6];
        for (int k = 0; k < 6; k++) begin
          s ^= s << 13; s ^= s >> 17; s ^= s << 5;
          f[k] = int'(s % 8);
        end
        drive(f[0], f[1], f[2], f[3], f[4], f[5] % 5, "R2 sweep");
      end
    end

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule